// File: doc/BRIEF.md
# Sigma-Delta Bitstream Gain Tap

This block feeds the one-bit output of an ADC sigma-delta modulator forward into the DAC datapath. On every cycle in which a modulator bit and an interpolator output sample are both valid, it adds a programmable signed coefficient to the sample or subtracts the coefficient from it. The modulator bit decides which: a 1 adds and a 0 subtracts. The result is clamped to the signed sample range and is presented one cycle later with its own valid strobe.

The coefficient is a two's complement fraction with full scale at -1.0. For example, 0x8000 is -1.0, 0xC000 is -0.5, 0x4000 is +0.5 and 0x7FFF is just below +1.0. It is loaded through a byte-wide configuration write port as two bytes. The new value takes effect only once both halves have arrived, so the datapath never sees a half-updated coefficient. After reset the coefficient is zero, and samples pass through unchanged.

Top module: `sd_gain_tap`

## Requirements
- R1: After reset, out_vld is 0, out_smp is 0 and the coefficient is 0x0000, so a sample passes through unchanged with either modulator bit value.
- R2: When mod_bit is 1, the result is smp_in plus the coefficient, both read as signed 16-bit values.
- R3: When mod_bit is 0, the result is smp_in minus the coefficient.
- R4: A result above +32767 is output as 0x7FFF. This includes subtracting 0x8000 (-1.0) from a non-negative sample.
- R5: A result below -32768 is output as 0x8000.
- R6: An operation takes place only on a cycle where mod_vld and smp_vld are both 1. out_vld is 1 on exactly the following cycle, carrying that result. On every other cycle out_vld is 0 and out_smp holds its value.
- R7: A write to cfg_addr 0 stages the coefficient's high byte (bits 15:8), and a write to cfg_addr 1 stages its low byte (bits 7:0). The coefficient in use changes only on the cycle after both bytes have been written, in either order. A single byte on its own has no effect.
- R8: Writes to cfg_addr 2 and 3 change neither the coefficient nor the staged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mod_bit | input | 1 | Modulator output bit: 1 adds the coefficient, 0 subtracts it |
| mod_vld | input | 1 | mod_bit is valid |
| smp_in | input | DATA_W | Interpolator output sample, signed |
| smp_vld | input | 1 | smp_in is valid |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Configuration byte address: 0 = high byte, 1 = low byte |
| cfg_wdata | input | DATA_W/2 | Configuration byte data |
| out_smp | output | DATA_W | Summed and saturated sample |
| out_vld | output | 1 | out_smp carries a new result |

## Verification
The bench builds the block with its default DATA_W of 16, so the coefficient is split into two 8-bit bytes and its fractional values match the table in the requirements. At this width, a handful of samples can reach both saturation limits, including the exact edge where a sum lands on 0x7FFF without clamping. The same width also exposes the asymmetric case of subtracting -1.0. Partial coefficient writes and writes to unused addresses are checked by how they change the sum.

// File: rtl/sdgt_pkg.sv
package sdgt_pkg;
  localparam int unsigned CFG_ADDR_W = 2;

  typedef enum logic [CFG_ADDR_W-1:0] {
    CFG_COEF_HI = 2'd0,
    CFG_COEF_LO = 2'd1
  } cfg_addr_e;
endpackage

// File: rtl/sdgt_rst_sync.sv
module sdgt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/sdgt_coef_regs.sv
module sdgt_coef_regs
  import sdgt_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  localparam int unsigned BYTE_W = COEF_W / 2
) (
  input  logic                  clk,
  input  logic                  rst_sn,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0]     cfg_wdata,
  output logic [COEF_W-1:0]     coef
);
  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              hi_seen_q, hi_seen_d, lo_seen_q, lo_seen_d;
  logic [COEF_W-1:0] coef_q, coef_d;
  logic              commit;

  always_comb begin
    hi_d      = hi_q;
    lo_d      = lo_q;
    hi_seen_d = hi_seen_q;
    lo_seen_d = lo_seen_q;
    coef_d    = coef_q;
    if (cfg_we) begin
      if (cfg_addr == CFG_COEF_HI) begin
        hi_d      = cfg_wdata;
        hi_seen_d = 1'b1;
      end else if (cfg_addr == CFG_COEF_LO) begin
        lo_d      = cfg_wdata;
        lo_seen_d = 1'b1;
      end
    end
    commit = hi_seen_d && lo_seen_d;
    if (commit) begin
      coef_d    = {hi_d, lo_d};
      hi_seen_d = 1'b0;
      lo_seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hi_q      <= '0;
      lo_q      <= '0;
      hi_seen_q <= 1'b0;
      lo_seen_q <= 1'b0;
      coef_q    <= '0;
    end else begin
      hi_q      <= hi_d;
      lo_q      <= lo_d;
      hi_seen_q <= hi_seen_d;
      lo_seen_q <= lo_seen_d;
      coef_q    <= coef_d;
    end
  end

  assign coef = coef_q;
endmodule

// File: rtl/sdgt_sat_addsub.sv
module sdgt_sat_addsub #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              add,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0] a_x, b_x, sum;

  always_comb begin
    a_x = {a[DATA_W-1], a};
    b_x = {b[DATA_W-1], b};
    sum = add ? (a_x + b_x) : (a_x - b_x);
    if (sum[DATA_W] != sum[DATA_W-1])
      y = sum[DATA_W] ? MAX_NEG : MAX_POS;
    else
      y = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/sd_gain_tap.sv
module sd_gain_tap
  import sdgt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned BYTE_W = DATA_W / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mod_bit,
  input  logic                  mod_vld,
  input  logic [DATA_W-1:0]     smp_in,
  input  logic                  smp_vld,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     out_smp,
  output logic                  out_vld
);
  logic              rst_sn;
  logic [DATA_W-1:0] coef_q;
  logic [DATA_W-1:0] sum;
  logic              fire;
  logic [DATA_W-1:0] smp_q, smp_d;
  logic              vld_q, vld_d;

  sdgt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sdgt_coef_regs #(.COEF_W(DATA_W)) u_coef (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .coef      (coef_q)
  );

  sdgt_sat_addsub #(.DATA_W(DATA_W)) u_sum (
    .add (mod_bit),
    .a   (smp_in),
    .b   (coef_q),
    .y   (sum)
  );

  always_comb begin
    fire  = mod_vld && smp_vld;
    vld_d = fire;
    smp_d = fire ? sum : smp_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      vld_q <= vld_d;
    end
  end

  assign out_smp = smp_q;
  assign out_vld = vld_q;
endmodule

// File: rtl/sd_gain_tap_chk.sv
module sd_gain_tap_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              mod_bit,
  input logic              mod_vld,
  input logic              smp_vld,
  input logic [DATA_W-1:0] smp_in,
  input logic              cfg_we,
  input logic [DATA_W-1:0] coef_q,
  input logic [DATA_W-1:0] out_smp,
  input logic              out_vld
);
  // R6
  out_vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mod_vld && smp_vld) |=> out_vld);

  // R6
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mod_vld && smp_vld) |=> (!out_vld && $stable(out_smp)));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mod_vld && smp_vld && mod_bit && !smp_in[DATA_W-1] && !coef_q[DATA_W-1])
      |=> !out_smp[DATA_W-1]);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mod_vld && smp_vld && !mod_bit && smp_in[DATA_W-1] && !coef_q[DATA_W-1])
      |=> out_smp[DATA_W-1]);

  // R7
  coef_write_only_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_we |=> $stable(coef_q));
endmodule

bind sd_gain_tap sd_gain_tap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .mod_bit (mod_bit),
  .mod_vld (mod_vld),
  .smp_vld (smp_vld),
  .smp_in  (smp_in),
  .cfg_we  (cfg_we),
  .coef_q  (coef_q),
  .out_smp (out_smp),
  .out_vld (out_vld)
);

// File: tb/sd_gain_tap_test.sv
module sd_gain_tap_test;
  localparam int DW = 16;
  localparam int NV = 10;
  // {coef[15:0], bit, sample[15:0], expected[15:0]}
  localparam logic [48:0] VEC [NV] = '{
    {16'h4000, 1'b1, 16'h1000, 16'h5000},  // R2
    {16'h4000, 1'b0, 16'h1000, 16'hD000},  // R3
    {16'hC000, 1'b1, 16'h1000, 16'hD000},  // R2
    {16'hC000, 1'b0, 16'h1000, 16'h5000},  // R3
    {16'h7FFF, 1'b1, 16'h7000, 16'h7FFF},  // R4
    {16'h8000, 1'b0, 16'h0001, 16'h7FFF},  // R4
    {16'h4000, 1'b0, 16'h9000, 16'h8000},  // R5
    {16'h8000, 1'b1, 16'h8000, 16'h8000},  // R5
    {16'h0123, 1'b1, 16'h0000, 16'h0123},  // R2
    {16'h2000, 1'b1, 16'h5FFF, 16'h7FFF}   // R4 edge, no clamp
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_bit = 1'b0, mod_vld = 1'b0, smp_vld = 1'b0, cfg_we = 1'b0;
  logic [DW-1:0] smp_in = '0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [DW-1:0] out_smp;
  logic out_vld;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  sd_gain_tap uut (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_vld(mod_vld),
    .smp_in(smp_in), .smp_vld(smp_vld), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_smp(out_smp), .out_vld(out_vld)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coef(input logic [15:0] c);
    wr(2'd0, c[15:8]);
    wr(2'd1, c[7:0]);
  endtask

  // one beat with given valids; checks out_vld next cycle, returns out_smp
  task automatic beat(input logic b, input logic mv, input logic sv,
                      input logic [DW-1:0] s, input string req,
                      output logic [DW-1:0] res);
    @(negedge clk);
    mod_bit = b; mod_vld = mv; smp_vld = sv; smp_in = s;
    @(negedge clk);
    mod_vld = 1'b0; smp_vld = 1'b0;
    check(req, {15'd0, out_vld}, {15'd0, mv && sv});
    res = out_smp;
  endtask

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_vld", {15'd0, out_vld}, 16'd0);
    check("R1 out_smp", out_smp, 16'h0000);
    beat(1'b1, 1'b1, 1'b1, 16'h1234, "R1 vld", r);
    check("R1 passthrough add", r, 16'h1234);
    beat(1'b0, 1'b1, 1'b1, 16'hABCD, "R1 vld", r);
    check("R1 passthrough sub", r, 16'hABCD);

    // vector table
    for (int i = 0; i < NV; i++) begin
      set_coef(VEC[i][48:33]);
      beat(VEC[i][32], 1'b1, 1'b1, VEC[i][31:16], "R6 vld", r);
      check($sformatf("R2-5 vec%0d", i), r, VEC[i][15:0]);
    end

    // R6: single valid does nothing, output holds
    set_coef(16'h0100);
    beat(1'b1, 1'b1, 1'b1, 16'h0001, "R6 vld", r);
    held = r;
    beat(1'b1, 1'b1, 1'b0, 16'h2222, "R6 mod only", r);
    check("R6 hold mod only", r, held);
    beat(1'b1, 1'b0, 1'b1, 16'h3333, "R6 smp only", r);
    check("R6 hold smp only", r, held);

    // R7: single byte has no effect, pair in reverse order commits
    wr(2'd0, 8'h20);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R7 vld", r);
    check("R7 hi only no effect", r, 16'h0100);
    wr(2'd1, 8'h05);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R7 vld", r);
    check("R7 commit hi then lo", r, 16'h2005);
    wr(2'd1, 8'h07);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R7 vld", r);
    check("R7 lo only no effect", r, 16'h2005);
    wr(2'd0, 8'h11);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R7 vld", r);
    check("R7 commit lo then hi", r, 16'h1107);

    // R8: unused addresses ignored, do not count as a staged byte
    wr(2'd2, 8'h55);
    wr(2'd3, 8'h66);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R8 vld", r);
    check("R8 coef unchanged", r, 16'h1107);
    wr(2'd0, 8'h01);
    wr(2'd3, 8'h77);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R8 vld", r);
    check("R8 no commit via addr3", r, 16'h1107);
    wr(2'd1, 8'h02);
    beat(1'b1, 1'b1, 1'b1, 16'h0000, "R8 vld", r);
    check("R8 staged bytes kept", r, 16'h0102);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule